// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Late-Arrival Retargeting

This block runs exception entry for a small pipelined core. It latches a vector of external interrupt requests, each with a programmable 8-bit priority, and selects the most urgent pending line whose priority beats the level currently running. On acceptance it pushes an eight-word context frame through a stack write port. In parallel it reads the handler address from the vector table through a separate request/response port. When both are finished it pulses `exec_start`, which marks the first handler instruction reaching execute.

While an entry is in flight, a strictly more urgent request retargets it. The block issues a new vector read for the new exception and updates the reported exception number and priority. The stack frame already under way is neither restarted nor written twice. After `exec_start`, a more urgent request is a normal nested pre-emption and takes a complete new frame. A request that is displaced stays pending and is entered later in priority order, once `handler_done` returns the block to idle. Unstacking, tail-chaining and nested return are not part of this block.

Both memory ports follow valid/ready rules. The stack port holds `stk_valid`, `stk_addr` and `stk_data` steady while `stk_ready` is low, and moves one word per handshake. The vector port issues one read at a time. It waits for the response before issuing the next read. A response that belongs to a superseded read is discarded. While a vector read has not yet been accepted, a late arrival may replace its address. `ctx_regs` and `sp_in` must be held steady for the whole entry.

Top module: `ies_entry_seq`

## Requirements
- R1: After reset (synchronous, active-low), `cur_prio` is 0xFF, `act_excnum` is 0, `stk_valid`, `vec_req_valid` and `exec_start` are low, and no request is pending.
- R2: Among pending lines, the one with the lowest priority value is chosen, and ties go to the lower line number. A line is taken only if its value is strictly below `cur_prio`, so a line at priority 0xFF is never taken.
- R3: Line n becomes exception number n+16 on `act_excnum`. Its vector read address is the exception number times 4: line 2 reads 0x48, line 8 reads 0x60, line 9 reads 0x64 and line 12 reads 0x70. `handler_pc` takes the vector response data.
- R4: The frame is eight words at base = (sp_in with bits [2:0] cleared) - 32. Word k is written to base+4k with `ctx_regs[32k+31:32k]`, where words 0..7 are r0, r1, r2, r3, r12, LR, PC, xPSR.
- R5: While `stk_valid` is high and `stk_ready` is low, the stack address and data hold. Exactly one frame word is consumed per handshake.
- R6: With `stk_ready` held high and each vector response arriving one cycle after acceptance, `exec_start` is high exactly 8 cycles after the first cycle with `stk_valid` high.
- R7: A late arrival is a request strictly more urgent than the target, arriving before `exec_start`. It causes a new vector read, and `act_excnum` and `cur_prio` switch to the new exception. The entry still writes exactly eight stack words.
- R8: During entry, a request of equal or lower urgency does not change the target or cause another vector read.
- R9: After `exec_start`, a strictly more urgent request starts a full new entry with eight further stack writes.
- R10: While a handler is active, a request of equal or lower urgency causes no stack write and no change of `act_excnum`.
- R11: A request seen for one cycle stays pending until its entry completes. A request displaced by a late arrival is entered after `handler_done`.
- R12: `exec_start` is a one-cycle pulse. `handler_done` while active returns `act_excnum` to 0 and `cur_prio` to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_IRQ | Interrupt request lines, latched as pending |
| irq_prio | input | NUM_IRQ*8 | Priority of line n in bits [8n+7:8n], lower is more urgent |
| handler_done | input | 1 | Active handler finished |
| sp_in | input | 32 | Stack pointer before entry |
| ctx_regs | input | 256 | Context words r0, r1, r2, r3, r12, LR, PC, xPSR, word k at [32k+31:32k] |
| stk_valid | output | 1 | Stack write request |
| stk_ready | input | 1 | Stack write accepted |
| stk_addr | output | 32 | Stack write address |
| stk_data | output | 32 | Stack write data |
| vec_req_valid | output | 1 | Vector read request |
| vec_req_ready | input | 1 | Vector read accepted |
| vec_addr | output | 32 | Vector table offset |
| vec_rsp_valid | input | 1 | Vector read data valid |
| vec_rsp_data | input | 32 | Vector read data |
| handler_pc | output | 32 | Handler address from the last accepted vector read |
| exec_start | output | 1 | First handler instruction reaches execute |
| act_excnum | output | 9 | Exception being entered or active, 0 when idle |
| cur_prio | output | 8 | Priority of that exception, 0xFF when idle |

## Verification
A single isolated request confirms frame layout, vector address and the 8-cycle latency. A second, more urgent line injected mid-entry must produce two vector reads but only one frame. An equal-priority injection at the same point must produce one read, which separates strict from non-strict comparison. Simultaneous equal-priority requests expose the tie rule. Requests raised after `exec_start` separate nested pre-emption (a full new frame) from late arrival, and separate both from lower-urgency requests that must be ignored. A stalled stack port and a priority-0xFF line cover back-pressure and the never-taken level.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int EXC_W    = 9;
  localparam int EXT_BASE = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ENTRY,
    SEQ_ACTIVE
  } seq_state_t;
endpackage

// File: rtl/ies_arbiter.sv
// Picks the most urgent pending line; strict compare keeps the lower index on ties.
module ies_arbiter #(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_IRQ-1:0]        pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic                      best_vld,
  output logic [IDX_W-1:0]          best_idx,
  output logic [PRIO_W-1:0]         best_prio
);
  logic [PRIO_W-1:0] prio_arr [NUM_IRQ];

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_slice
      assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
    end
  endgenerate

  always_comb begin
    best_vld  = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend[i] && (!best_vld || (prio_arr[i] < best_prio))) begin
        best_vld  = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio_arr[i];
      end
    end
  end
endmodule

// File: rtl/ies_stacker.sv
// Walks the context frame out through a valid/ready write port.
module ies_stacker #(
  parameter int XLEN        = 32,
  parameter int FRAME_WORDS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [XLEN-1:0]             sp_in,
  input  logic [FRAME_WORDS*XLEN-1:0] ctx_flat,
  output logic                        stk_valid,
  input  logic                        stk_ready,
  output logic [XLEN-1:0]             stk_addr,
  output logic [XLEN-1:0]             stk_data,
  output logic                        fin
);
  localparam int BEAT_W      = $clog2(FRAME_WORDS + 1);
  localparam int WIDX_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam int WORD_BYTES  = XLEN / 8;
  localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(FRAME_WORDS - 1);
  localparam logic [BEAT_W-1:0] END_BEAT  = BEAT_W'(FRAME_WORDS);

  logic [BEAT_W-1:0] beat_q;
  logic [XLEN-1:0]   base_q;
  logic [WIDX_W-1:0] widx;
  logic              hs;

  assign widx      = beat_q[WIDX_W-1:0];
  assign stk_valid = (beat_q < END_BEAT);
  assign stk_addr  = base_q + XLEN'(beat_q) * XLEN'(WORD_BYTES);
  assign stk_data  = ctx_flat[widx*XLEN +: XLEN];
  assign hs        = stk_valid && stk_ready;
  assign fin       = (beat_q == END_BEAT) || (hs && (beat_q == LAST_BEAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q <= END_BEAT;
      base_q <= '0;
    end else if (start) begin
      beat_q <= '0;
      base_q <= {sp_in[XLEN-1:3], 3'b000} - XLEN'(FRAME_BYTES);
    end else if (hs) begin
      beat_q <= beat_q + BEAT_W'(1);
    end
  end
endmodule

// File: rtl/ies_vecfetch.sv
// One outstanding vector read; a retarget marks an in-flight read stale.
module ies_vecfetch #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [XLEN-1:0] launch_addr,
  output logic            vec_req_valid,
  input  logic            vec_req_ready,
  output logic [XLEN-1:0] vec_addr,
  input  logic            vec_rsp_valid,
  input  logic [XLEN-1:0] vec_rsp_data,
  output logic            got,
  output logic [XLEN-1:0] pc
);
  logic            need_q, wait_q, stale_q, got_q;
  logic [XLEN-1:0] addr_q, pc_q;
  logic            req_hs, rsp_hit;

  assign vec_req_valid = need_q && !wait_q;
  assign vec_addr      = addr_q;
  assign req_hs        = vec_req_valid && vec_req_ready;
  assign rsp_hit       = vec_rsp_valid && wait_q;
  assign got           = got_q;
  assign pc            = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need_q  <= 1'b0;
      wait_q  <= 1'b0;
      stale_q <= 1'b0;
      got_q   <= 1'b0;
      addr_q  <= '0;
      pc_q    <= '0;
    end else begin
      if (req_hs) begin
        need_q <= 1'b0;
        wait_q <= 1'b1;
      end
      if (rsp_hit) begin
        wait_q  <= 1'b0;
        stale_q <= 1'b0;
        if (!stale_q && !launch) begin
          got_q <= 1'b1;
          pc_q  <= vec_rsp_data;
        end
      end
      if (launch) begin
        need_q <= 1'b1;
        addr_q <= launch_addr;
        got_q  <= 1'b0;
        if ((wait_q && !vec_rsp_valid) || req_hs) stale_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ies_entry_seq.sv
module ies_entry_seq #(
  parameter int NUM_IRQ     = 16,
  parameter int PRIO_W      = 8,
  parameter int XLEN        = 32,
  parameter int FRAME_WORDS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_IRQ-1:0]          irq_req,
  input  logic [NUM_IRQ*PRIO_W-1:0]   irq_prio,
  input  logic                        handler_done,
  input  logic [XLEN-1:0]             sp_in,
  input  logic [FRAME_WORDS*XLEN-1:0] ctx_regs,
  output logic                        stk_valid,
  input  logic                        stk_ready,
  output logic [XLEN-1:0]             stk_addr,
  output logic [XLEN-1:0]             stk_data,
  output logic                        vec_req_valid,
  input  logic                        vec_req_ready,
  output logic [XLEN-1:0]             vec_addr,
  input  logic                        vec_rsp_valid,
  input  logic [XLEN-1:0]             vec_rsp_data,
  output logic [XLEN-1:0]             handler_pc,
  output logic                        exec_start,
  output logic [ies_pkg::EXC_W-1:0]   act_excnum,
  output logic [PRIO_W-1:0]           cur_prio
);
  import ies_pkg::*;

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  seq_state_t           state_q;
  logic [NUM_IRQ-1:0]   pend_q, clr_mask;
  logic                 best_vld;
  logic [IDX_W-1:0]     best_idx, tgt_q;
  logic [PRIO_W-1:0]    best_prio, cur_q;
  logic [EXC_W-1:0]     best_exc, act_q;
  logic                 take, stk_start, vec_launch, go_active, go_idle;
  logic                 stk_fin, vec_got, exec_q;

  ies_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .pend(pend_q), .prio_flat(irq_prio),
    .best_vld(best_vld), .best_idx(best_idx), .best_prio(best_prio)
  );

  assign best_exc = EXC_W'(best_idx) + EXC_W'(EXT_BASE);
  assign take     = best_vld && (best_prio < cur_q);

  ies_stacker #(.XLEN(XLEN), .FRAME_WORDS(FRAME_WORDS)) u_stk (
    .clk(clk), .rst_n(rst_n), .start(stk_start), .sp_in(sp_in),
    .ctx_flat(ctx_regs), .stk_valid(stk_valid), .stk_ready(stk_ready),
    .stk_addr(stk_addr), .stk_data(stk_data), .fin(stk_fin)
  );

  ies_vecfetch #(.XLEN(XLEN)) u_vec (
    .clk(clk), .rst_n(rst_n), .launch(vec_launch),
    .launch_addr(XLEN'(best_exc) << 2),
    .vec_req_valid(vec_req_valid), .vec_req_ready(vec_req_ready),
    .vec_addr(vec_addr), .vec_rsp_valid(vec_rsp_valid),
    .vec_rsp_data(vec_rsp_data), .got(vec_got), .pc(handler_pc)
  );

  always_comb begin
    stk_start  = 1'b0;
    vec_launch = 1'b0;
    go_active  = 1'b0;
    go_idle    = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (take) begin
          stk_start  = 1'b1;
          vec_launch = 1'b1;
        end
      end
      SEQ_ENTRY: begin
        if (take)                    vec_launch = 1'b1;
        else if (stk_fin && vec_got) go_active  = 1'b1;
      end
      SEQ_ACTIVE: begin
        if (take) begin
          stk_start  = 1'b1;
          vec_launch = 1'b1;
        end else if (handler_done) begin
          go_idle = 1'b1;
        end
      end
      default: ;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_clr
      assign clr_mask[g] = go_active && (tgt_q == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      tgt_q   <= '0;
      act_q   <= '0;
      cur_q   <= '1;
      exec_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q | irq_req) & ~clr_mask;
      exec_q <= go_active;
      if (vec_launch) begin
        tgt_q <= best_idx;
        act_q <= best_exc;
        cur_q <= best_prio;
      end
      if (stk_start) begin
        state_q <= SEQ_ENTRY;
      end else if (go_active) begin
        state_q <= SEQ_ACTIVE;
      end else if (go_idle) begin
        state_q <= SEQ_IDLE;
        act_q   <= '0;
        cur_q   <= '1;
      end
    end
  end

  assign exec_start = exec_q;
  assign act_excnum = act_q;
  assign cur_prio   = cur_q;
endmodule

// File: rtl/ies_entry_chk.sv
module ies_entry_chk #(
  parameter int PRIO_W = 8,
  parameter int XLEN   = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      stk_valid,
  input logic                      stk_ready,
  input logic [XLEN-1:0]           stk_addr,
  input logic [XLEN-1:0]           stk_data,
  input logic                      vec_req_valid,
  input logic [XLEN-1:0]           vec_addr,
  input logic                      exec_start,
  input logic [ies_pkg::EXC_W-1:0] act_excnum,
  input logic [PRIO_W-1:0]         cur_prio
);
  assert_idle_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_excnum == '0) |-> (cur_prio == '1));

  assert_vec_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_valid |-> (vec_addr == (XLEN'(act_excnum) << 2)));

  assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid |-> (stk_addr[1:0] == 2'b00));

  assert_stk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) && $stable(stk_data)));

  assert_retarget_urgent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_excnum != '0) && ($past(act_excnum) != '0) && (act_excnum != $past(act_excnum)))
      |-> (cur_prio < $past(cur_prio)));

  assert_exec_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  assert_exec_has_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (act_excnum >= ies_pkg::EXC_W'(ies_pkg::EXT_BASE)));
endmodule

bind ies_entry_seq ies_entry_chk #(.PRIO_W(PRIO_W), .XLEN(XLEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .stk_valid(stk_valid), .stk_ready(stk_ready),
  .stk_addr(stk_addr), .stk_data(stk_data), .vec_req_valid(vec_req_valid),
  .vec_addr(vec_addr), .exec_start(exec_start), .act_excnum(act_excnum),
  .cur_prio(cur_prio)
);

// File: tb/test_ies_entry_seq.sv
module test_ies_entry_seq;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic [7:0]    prio_cfg [N];
  logic [N*8-1:0] irq_prio;
  logic          handler_done = 1'b0;
  logic [31:0]   sp_in = 32'h2000_0400;
  logic [31:0]   ctx_seed = 32'hA000_0000;
  logic [255:0]  ctx_regs;
  logic          stk_valid, stk_ready = 1'b1;
  logic [31:0]   stk_addr, stk_data;
  logic          vec_req_valid, vec_req_ready = 1'b1;
  logic [31:0]   vec_addr;
  logic          vec_rsp_valid = 1'b0;
  logic [31:0]   vec_rsp_data = '0;
  logic [31:0]   handler_pc;
  logic          exec_start;
  logic [8:0]    act_excnum;
  logic [7:0]    cur_prio;

  int errors = 0, checks = 0, cyc = 0, stk_cnt = 0, vec_cnt = 0;
  bit stall_mode = 1'b0;
  logic        vhs_seen = 1'b0;
  logic [31:0] vaddr_seen = '0;
  logic [63:0] exp_stk [$];
  logic [31:0] exp_vec [$];

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) irq_prio[k*8 +: 8] = prio_cfg[k];
    for (int k = 0; k < 8; k++) ctx_regs[k*32 +: 32] = ctx_seed + 32'(k);
  end

  ies_entry_seq i_ies_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio),
    .handler_done(handler_done), .sp_in(sp_in), .ctx_regs(ctx_regs),
    .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_addr(stk_addr),
    .stk_data(stk_data), .vec_req_valid(vec_req_valid),
    .vec_req_ready(vec_req_ready), .vec_addr(vec_addr),
    .vec_rsp_valid(vec_rsp_valid), .vec_rsp_data(vec_rsp_data),
    .handler_pc(handler_pc), .exec_start(exec_start),
    .act_excnum(act_excnum), .cur_prio(cur_prio)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] actual, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, actual, expv);
    end
  endtask

  // Memory model: responses and ready change shortly after the rising edge.
  always @(posedge clk) begin
    cyc++;
    #2;
    vec_rsp_valid = vhs_seen;
    vec_rsp_data  = 32'h0800_0000 | vaddr_seen;
    stk_ready     = stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor: handshakes seen mid-cycle complete at the following edge.
  always @(negedge clk) begin
    vhs_seen   = vec_req_valid && vec_req_ready;
    vaddr_seen = vec_addr;
    if (rst_n && stk_valid && stk_ready) begin
      stk_cnt++;
      if (exp_stk.size() == 0) begin
        chk(1'b0, "R7", "unexpected stack write", stk_addr, 32'h0);
      end else begin
        logic [63:0] e;
        e = exp_stk.pop_front();
        chk(stk_addr == e[63:32], "R4", "stack address", stk_addr, e[63:32]);
        chk(stk_data == e[31:0], "R4", "stack data", stk_data, e[31:0]);
      end
    end
    if (rst_n && vec_req_valid && vec_req_ready) begin
      vec_cnt++;
      if (exp_vec.size() == 0) begin
        chk(1'b0, "R8", "unexpected vector read", vec_addr, 32'h0);
      end else begin
        logic [31:0] v;
        v = exp_vec.pop_front();
        chk(vec_addr == v, "R3", "vector address", vec_addr, v);
      end
    end
  end

  task automatic push_frame(input logic [31:0] sp, input logic [31:0] sd);
    logic [31:0] base;
    sp_in    = sp;
    ctx_seed = sd;
    base     = (sp & 32'hFFFF_FFF8) - 32'd32;
    for (int k = 0; k < 8; k++) exp_stk.push_back({base + 32'(4*k), sd + 32'(k)});
  endtask

  task automatic push_vec(input int line);
    exp_vec.push_back(32'((line + 16) * 4));
  endtask

  task automatic pulse_irq(input logic [N-1:0] m);
    @(negedge clk) irq_req = m;
    @(negedge clk) irq_req = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk) handler_done = 1'b1;
    @(negedge clk) handler_done = 1'b0;
  endtask

  task automatic wait_stk();
    do @(negedge clk); while (!stk_valid);
  endtask

  task automatic wait_exec();
    do @(negedge clk); while (!exec_start);
  endtask

  task automatic measure(output int lat);
    int t0;
    wait_stk();
    t0 = cyc;
    wait_exec();
    lat = cyc - t0;
  endtask

  task automatic expect_active(input string req, input int line, input logic [7:0] p);
    chk(act_excnum == 9'(line + 16), req, "active exception", 32'(act_excnum), 32'(line + 16));
    chk(cur_prio == p, req, "current priority", 32'(cur_prio), 32'(p));
    chk(handler_pc == (32'h0800_0000 | 32'((line + 16) * 4)), "R3", "handler pc",
        handler_pc, 32'h0800_0000 | 32'((line + 16) * 4));
  endtask

  task automatic expect_idle(input string req);
    chk(act_excnum == 9'd0, req, "idle exception", 32'(act_excnum), 32'd0);
    chk(cur_prio == 8'hFF, req, "idle priority", 32'(cur_prio), 32'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int lat, s0;
    for (int k = 0; k < N; k++) prio_cfg[k] = 8'h80;
    prio_cfg[2] = 8'h40;
    prio_cfg[8] = 8'h10;
    prio_cfg[9] = 8'h40;
    irq_req = '1;
    repeat (3) @(negedge clk);
    // R1: reset state, with requests held during reset not latched
    expect_idle("R1");
    chk(!stk_valid && !vec_req_valid && !exec_start, "R1", "valids low", 32'(stk_valid), 32'd0);
    irq_req = '0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stk_cnt == 0 && act_excnum == 0, "R1", "no pending after reset", 32'(stk_cnt), 32'd0);

    // R6 R3 R4: single request, unaligned stack pointer
    push_frame(32'h2000_0104, 32'h1111_0000);
    push_vec(2);
    pulse_irq(N'(1) << 2);
    measure(lat);
    chk(lat == 8, "R6", "entry latency", 32'(lat), 32'd8);
    expect_active("R3", 2, 8'h40);
    @(negedge clk);
    chk(!exec_start, "R12", "exec pulse width", 32'(exec_start), 32'd0);
    done_pulse();
    expect_idle("R12");

    // R7: late arrival of line 8 during line 2 entry
    s0 = stk_cnt;
    push_frame(32'h2000_0300, 32'h2222_0000);
    push_vec(2);
    push_vec(8);
    pulse_irq(N'(1) << 2);
    wait_stk();
    @(negedge clk);
    pulse_irq(N'(1) << 8);
    wait_exec();
    expect_active("R7", 8, 8'h10);
    chk(stk_cnt - s0 == 8, "R7", "single frame", 32'(stk_cnt - s0), 32'd8);
    // R11: displaced line 2 is entered after the handler finishes
    push_frame(32'h2000_0200, 32'h3333_0000);
    push_vec(2);
    done_pulse();
    wait_exec();
    expect_active("R11", 2, 8'h40);
    done_pulse();

    // R8: equal priority during entry does not retarget
    s0 = vec_cnt;
    push_frame(32'h2000_0500, 32'h4444_0000);
    push_vec(2);
    pulse_irq(N'(1) << 2);
    wait_stk();
    @(negedge clk);
    pulse_irq(N'(1) << 9);
    wait_exec();
    expect_active("R8", 2, 8'h40);
    chk(vec_cnt - s0 == 1, "R8", "vector reads", 32'(vec_cnt - s0), 32'd1);
    push_frame(32'h2000_0500, 32'h5555_0000);
    push_vec(9);
    done_pulse();
    wait_exec();
    expect_active("R11", 9, 8'h40);
    done_pulse();
    expect_idle("R12");

    // R2: tie between lines 8 and 9 goes to line 8
    prio_cfg[8] = 8'h30;
    prio_cfg[9] = 8'h30;
    push_frame(32'h2000_0600, 32'h6666_0000);
    push_vec(8);
    pulse_irq((N'(1) << 8) | (N'(1) << 9));
    wait_exec();
    expect_active("R2", 8, 8'h30);
    push_frame(32'h2000_0600, 32'h6767_0000);
    push_vec(9);
    done_pulse();
    wait_exec();
    expect_active("R2", 9, 8'h30);
    done_pulse();

    // R10 R9: lower request ignored while active, then nested pre-emption
    prio_cfg[8]  = 8'h10;
    prio_cfg[12] = 8'h80;
    push_frame(32'h2000_0700, 32'h7777_0000);
    push_vec(2);
    pulse_irq(N'(1) << 2);
    wait_exec();
    s0 = stk_cnt;
    pulse_irq(N'(1) << 12);
    repeat (12) @(negedge clk);
    chk(stk_cnt == s0, "R10", "no writes for lower request", 32'(stk_cnt - s0), 32'd0);
    chk(act_excnum == 9'd18, "R10", "active unchanged", 32'(act_excnum), 32'd18);
    push_frame(32'h2000_06E0, 32'h8888_0000);
    push_vec(8);
    pulse_irq(N'(1) << 8);
    wait_exec();
    expect_active("R9", 8, 8'h10);
    chk(stk_cnt - s0 == 8, "R9", "full new frame", 32'(stk_cnt - s0), 32'd8);
    push_frame(32'h2000_0800, 32'h9999_0000);
    push_vec(12);
    done_pulse();
    wait_exec();
    expect_active("R11", 12, 8'h80);
    done_pulse();

    // R5: stalled stack port
    stall_mode  = 1'b1;
    prio_cfg[3] = 8'h20;
    push_frame(32'h2000_0907, 32'hAAAA_0000);
    push_vec(3);
    pulse_irq(N'(1) << 3);
    measure(lat);
    chk(lat > 8, "R5", "stalled latency", 32'(lat), 32'd9);
    expect_active("R5", 3, 8'h20);
    done_pulse();
    stall_mode = 1'b0;

    // R2: priority 0xFF is never taken
    prio_cfg[5] = 8'hFF;
    s0 = stk_cnt;
    pulse_irq(N'(1) << 5);
    repeat (15) @(negedge clk);
    chk(stk_cnt == s0, "R2", "0xFF line ignored", 32'(stk_cnt - s0), 32'd0);
    expect_idle("R2");

    chk(exp_stk.size() == 0, "R4", "stack items left", 32'(exp_stk.size()), 32'd0);
    chk(exp_vec.size() == 0, "R7", "vector items left", 32'(exp_vec.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule